// File: doc/BRIEF.md
# Speaker Gate and Status Control Port

This block is a single 8-bit control and status register that sits beside a three-channel interval timer. A write sets two controls: the gate level of timer channel 2 and an enable that lets the channel 2 output reach the speaker. The gated speaker signal is produced here as well.

A read returns a status byte. It holds the live channel 2 output, the two control bits as the timer sees them, and a refresh indicator. The refresh indicator flips after every read strobe, so polling software sees it alternate. The gate level reaches the timer one clock after the write. The timer therefore always sees a clean registered level and can detect edges on it.

Top module: `sysctl_port`

## Requirements
- R1: Bit 0 of a write sets the channel 2 gate; `gate_o` takes the new level on the second rising clock edge after the write cycle, not the first.
- R2: Bit 1 of a write sets the speaker enable; `spk_en_o` takes the new level on the first rising edge after the write cycle.
- R3: `rdata_o` carries `tmr_out_i` in bit 5, the refresh indicator in bit 4, `spk_en_o` in bit 1 and `gate_o` in bit 0, all live in the same cycle.
- R4: The refresh indicator (read bit 4) inverts on the edge that ends each cycle with `rd_en_i` high, and holds in every other cycle.
- R5: While `rst_ni` is low, the gate, the speaker enable and the refresh indicator are 0.
- R6: `spk_o` is high exactly when `tmr_out_i` and `spk_en_o` are both high.
- R7: Read bits 7, 6, 3 and 2 are always 0.
- R8: Write bits 7 to 2 have no effect, and without `wr_en_i` neither control bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe, one cycle per read |
| rdata_o | output | 8 | Status byte |
| tmr_out_i | input | 1 | Output of timer channel 2 |
| gate_o | output | 1 | Gate level to timer channel 2 |
| spk_en_o | output | 1 | Speaker data enable |
| spk_o | output | 1 | Channel 2 output gated by the speaker enable |

## Verification
The hardest case to create is the mismatch window after a write. For one cycle the speaker enable already shows the new value while the gate still shows the old one. A read that lands in that window must report both honestly. The stimulus reaches this case with back-to-back writes that flip the gate bit every cycle, with read and write strobes in the same cycle, and with gate reads placed right after a write. The model predicts each cycle, including the refresh bit across long runs of consecutive reads.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned BIT_GATE   = 0;
  localparam int unsigned BIT_SPK_EN = 1;
  localparam int unsigned BIT_REFR   = 4;
  localparam int unsigned BIT_TMROUT = 5;

  typedef struct packed {
    logic gate;
    logic spk_en;
  } ctrl_t;
endpackage

// File: rtl/sysctl_ctrl_reg.sv
module sysctl_ctrl_reg
  import sysctl_pkg::*;
#(
  parameter int unsigned GATE_STAGES = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output ctrl_t             ctrl_o
);
  logic                   gate_q;
  logic                   spk_q;
  logic [GATE_STAGES-1:0] gate_pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= 1'b0;
      spk_q  <= 1'b0;
    end else if (wr_en_i) begin
      gate_q <= wdata_i[BIT_GATE];
      spk_q  <= wdata_i[BIT_SPK_EN];
    end
  end

  // gate reaches the timer through a register stage so edges are clean
  generate
    if (GATE_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) gate_pipe_q <= '0;
        else         gate_pipe_q <= gate_q;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) gate_pipe_q <= '0;
        else         gate_pipe_q <= {gate_pipe_q[GATE_STAGES-2:0], gate_q};
      end
    end
  endgenerate

  assign ctrl_o.gate   = gate_pipe_q[GATE_STAGES-1];
  assign ctrl_o.spk_en = spk_q;
endmodule

// File: rtl/sysctl_refresh.sv
module sysctl_refresh (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_en_i,
  output logic refr_o
);
  logic refr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      refr_q <= 1'b0;
    else if (rd_en_i) refr_q <= ~refr_q;
  end

  assign refr_o = refr_q;
endmodule

// File: rtl/sysctl_rd_mux.sv
module sysctl_rd_mux
  import sysctl_pkg::*;
(
  input  ctrl_t             ctrl_i,
  input  logic              refr_i,
  input  logic              tmr_out_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    rdata_o             = '0;
    rdata_o[BIT_GATE]   = ctrl_i.gate;
    rdata_o[BIT_SPK_EN] = ctrl_i.spk_en;
    rdata_o[BIT_REFR]   = refr_i;
    rdata_o[BIT_TMROUT] = tmr_out_i;
  end
endmodule

// File: rtl/sysctl_port.sv
module sysctl_port
  import sysctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tmr_out_i,
  output logic              gate_o,
  output logic              spk_en_o,
  output logic              spk_o
);
  ctrl_t ctrl;
  logic  refr;

  sysctl_ctrl_reg #(.GATE_STAGES(1)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .wdata_i (wdata_i),
    .ctrl_o  (ctrl)
  );

  sysctl_refresh u_refr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_en_i (rd_en_i),
    .refr_o  (refr)
  );

  sysctl_rd_mux u_mux (
    .ctrl_i    (ctrl),
    .refr_i    (refr),
    .tmr_out_i (tmr_out_i),
    .rdata_o   (rdata_o)
  );

  assign gate_o   = ctrl.gate;
  assign spk_en_o = ctrl.spk_en;
  assign spk_o    = tmr_out_i & ctrl.spk_en;
endmodule

// File: rtl/sysctl_port_chk.sv
module sysctl_port_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [7:0] wdata_i,
  input logic       rd_en_i,
  input logic [7:0] rdata_o,
  input logic       tmr_out_i,
  input logic       gate_o,
  input logic       spk_en_o,
  input logic       spk_o
);
  logic past_wr_q;
  logic past_b0_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      past_wr_q <= 1'b0;
      past_b0_q <= 1'b0;
    end else begin
      past_wr_q <= wr_en_i;
      past_b0_q <= wdata_i[0];
    end
  end

  assert_gate_delay_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_wr_q |=> (gate_o == $past(past_b0_q)));

  assert_spk_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (spk_en_o == $past(wdata_i[1])));

  assert_read_map_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[5] == tmr_out_i) && (rdata_o[1] == spk_en_o) && (rdata_o[0] == gate_o));

  assert_refr_flip_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> (rdata_o[4] != $past(rdata_o[4])));

  assert_refr_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o[4]));

  assert_spk_and_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spk_o == (tmr_out_i & spk_en_o));

  assert_zero_bits_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[7:6] == 2'b00) && (rdata_o[3:2] == 2'b00));

  assert_no_wr_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(spk_en_o));
endmodule

bind sysctl_port sysctl_port_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wdata_i   (wdata_i),
  .rd_en_i   (rd_en_i),
  .rdata_o   (rdata_o),
  .tmr_out_i (tmr_out_i),
  .gate_o    (gate_o),
  .spk_en_o  (spk_en_o),
  .spk_o     (spk_o)
);

// File: tb/sysctl_port_tb.sv
`timescale 1ns/1ps
module sysctl_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       rd_en = 1'b0;
  logic [7:0] rdata;
  logic       tout = 1'b0;
  logic       gate, spk_en, spk;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  // reference state
  bit m_gate_pend, m_gate, m_spk, m_refr;

  always #2.5 clk = ~clk;

  sysctl_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wdata_i(wdata),
    .rd_en_i(rd_en), .rdata_o(rdata), .tmr_out_i(tout),
    .gate_o(gate), .spk_en_o(spk_en), .spk_o(spk)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1 gate", gate, m_gate);
    chk("R2 spk_en", spk_en, m_spk);
    chk("R3 bit5", rdata[5], tout);
    chk("R3 bit1", rdata[1], m_spk);
    chk("R3 bit0", rdata[0], m_gate);
    chk("R4 refresh", rdata[4], m_refr);
    chk("R6 spk", spk, tout & m_spk);
    chk("R7 zero bits", {rdata[7:6], rdata[3:2]}, 0);
  endtask

  // one cycle: drive after negedge, compare, then advance model at posedge
  task automatic step(input bit w, input bit r, input logic [7:0] d, input bit t);
    @(negedge clk);
    wr_en = w; rd_en = r; wdata = d; tout = t;
    #1;
    compare_all();
    @(posedge clk);
    m_gate = m_gate_pend;
    if (w) begin
      m_gate_pend = d[0];
      m_spk       = d[1];
    end
    if (r) m_refr = ~m_refr;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    // R5: reset state, write attempt during reset ignored
    wr_en = 1'b1; wdata = 8'hFF; rd_en = 1'b1; tout = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 gate", gate, 0);
    chk("R5 spk_en", spk_en, 0);
    chk("R5 rdata", rdata, 0);
    wr_en = 1'b0; rd_en = 1'b0; wdata = 8'h00;
    @(negedge clk);
    rst_n = 1'b1;

    // R8: upper write bits have no effect
    step(1, 0, 8'hFC, 1);
    step(0, 0, 8'h03, 1);
    step(0, 0, 8'h03, 1);
    // R1/R2 set both, then watch gate lag
    step(1, 0, 8'h03, 1);
    step(0, 1, 8'h00, 1);
    step(0, 1, 8'h00, 0);
    step(0, 0, 8'h00, 1);
    // gate toggling every cycle with simultaneous reads
    for (int i = 0; i < 10; i++) step(1, 1, 8'(i & 1), i[1]);
    // R4: long read run and idle holds
    for (int i = 0; i < 9; i++) step(0, 1, 8'hAA, 1);
    for (int i = 0; i < 4; i++) step(0, 0, 8'h55, 0);
    // speaker enable only, gate off
    step(1, 0, 8'hF2, 1);
    step(0, 0, 8'h00, 1);
    step(0, 0, 8'h00, 0);
    // mixed pattern
    for (int i = 0; i < 40; i++)
      step(((i * 7) % 3) == 0, ((i * 5) % 4) == 1, 8'((i * 37) & 8'hFF), ((i * 3) % 5) > 1);
    step(0, 0, 8'h00, 1);
    step(0, 0, 8'h00, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule